// File: doc/BRIEF.md
# ADC Conversion Start and Auto-Trigger Controller

This block decides when an analog-to-digital conversion begins and tracks it while it runs. Software can request a single conversion by writing a one to a start bit. Hardware can also start one on a rising edge of a trigger source, picked by a 3-bit select field. Hardware triggering works only while the auto-trigger enable is set. Select code 0 watches the block's own completion flag. Codes 1 to 7 watch the external inputs `trig_in[0]` to `trig_in[6]`.

A trigger start also restarts the divide-by-2 conversion prescaler, so conversions launched from a periodic source stay aligned to it. A 13-tick counter driven by the prescaler stands in for the converter's timing. The channel select is captured when a conversion starts. The completion flag is set at the end of every conversion and stays set until software writes a one to clear it.

The pins are all plain control and status pins. No data moves through the block, so it has no valid/ready interface and applies no back-pressure.

Top module: `adc_trig_ctrl`

## Requirements
- R1: While idle (`busy`=0), `sw_start`=1 asserts `start_pulse` in the same cycle. `busy` then reads 1 from the next cycle and returns to 0 by itself when the conversion ends.
- R2: `act_chan` takes the value of `chan_sel` in the cycle `start_pulse` is high. It does not change while `busy`=1, even if `chan_sel` changes.
- R3: Hardware starts happen only when `auto_en`=1. `trig_sel`=0 watches `done_flag`, and `trig_sel`=k (1..7) watches `trig_in[k-1]`. A rising edge on a source that is not selected starts nothing.
- R4: With `auto_en`=1, a rising edge on the selected source while idle asserts both `start_pulse` and `presc_rst` in that cycle. `presc_rst` is never high without `start_pulse`.
- R5: While `busy`=1, trigger edges and `sw_start` are ignored: `start_pulse` stays 0 and the running conversion is not lengthened.
- R6: A selected trigger that is still high when a conversion ends starts no new conversion. Only a low-to-high change can start one.
- R7: `done_flag` reads 1 in the first cycle after the conversion, when `busy` has dropped. It holds until a cycle with `flag_clr`=1. If the flag is being set and cleared in the same cycle, setting wins.
- R8: With `trig_sel`=0 and `auto_en`=1, the rise of `done_flag` starts the next conversion in that same cycle. While the flag stays high, later completions start nothing.
- R9: A rising edge means the selected source is high now and was low in the previous cycle. Changing `trig_sel` to an input that was already high in the previous cycle gives no start.
- R10: A conversion lasts 13 prescaler ticks at one tick every 2 cycles. A trigger start keeps `busy` high for exactly 26 cycles. A software start does not restart the prescaler, so it keeps `busy` high for 25 or 26 cycles.
- R11: A software start and a trigger edge in the same cycle launch exactly one conversion. That conversion restarts the prescaler, so it lasts 26 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software write of one to the start bit |
| auto_en | input | 1 | Hardware trigger enable |
| trig_sel | input | 3 | Trigger source select (0 = completion flag) |
| trig_in | input | 7 | External trigger inputs for select codes 1..7 |
| chan_sel | input | 3 | Requested input channel |
| flag_clr | input | 1 | Write of one that clears the completion flag |
| start_pulse | output | 1 | One-cycle conversion start |
| presc_rst | output | 1 | Prescaler restart, high on trigger starts |
| busy | output | 1 | Start bit readback, high while converting |
| act_chan | output | 3 | Channel latched for the current conversion |
| done_flag | output | 1 | Completion interrupt flag |

## Verification
The bench sweeps every select code with hardware triggering both off and on. In each case it raises a non-selected input first and then the selected one. A multiplexer wired to the wrong input, or an enable ignored, would start a conversion from the wrong pin or with triggering off.

Several more corner cases get targeted checks:
- Retriggers and software writes during a busy conversion: a design that accepts them would pulse `start_pulse` mid-conversion.
- A trigger held high past completion: a level-sensitive design would restart at once.
- A select switch onto an input that is already high: a design that keeps only the previous value of the selected line would see a false edge.
- The flag used as its own trigger: a design that ignores this case would either fail to chain conversions or keep chaining them without the flag being cleared.
- A software start coinciding with a trigger edge: a design that mishandles it would run two conversions or lose the prescaler restart.
- A clear that collides with completion: a design that gives clearing priority would lose the completion flag.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int unsigned NUM_SRC     = 8;   // select codes, code 0 = own flag
  localparam int unsigned CHAN_BITS   = 3;
  localparam int unsigned CONV_TICKS  = 13;  // prescaled periods per conversion
  localparam int unsigned PRESC_RATIO = 2;   // clock cycles per prescaled period

  typedef enum logic [1:0] {
    START_NONE = 2'd0,
    START_SW   = 2'd1,
    START_TRIG = 2'd2
  } start_kind_e;
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src,
  input  logic [SEL_W-1:0] sel,
  output logic             rise
);
  // Every source keeps its own previous sample, so a select switch compares
  // the newly chosen line against its own history.
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] rise_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_rise
    assign rise_vec[g] = src[g] & ~prev_q[g];
  end

  assign rise = rise_vec[sel];
endmodule

// File: rtl/conv_prescaler.sv
module conv_prescaler #(
  parameter int unsigned RATIO = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  if (RATIO <= 1) begin : g_bypass
    assign tick = 1'b1;
  end else begin : g_div
    localparam int unsigned CW = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart)        cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
  end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int unsigned TICKS = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int unsigned TW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  logic [TW-1:0] cnt_q;
  logic          busy_q;

  assign done = busy_q & tick & (cnt_q == LAST);
  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && tick) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int unsigned NSRC  = NUM_SRC,
  parameter int unsigned CH_W  = CHAN_BITS,
  parameter int unsigned TICKS = CONV_TICKS,
  parameter int unsigned RATIO = PRESC_RATIO,
  localparam int unsigned SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             auto_en,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic [NSRC-2:0]  trig_in,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             flag_clr,
  output logic             start_pulse,
  output logic             presc_rst,
  output logic             busy,
  output logic [CH_W-1:0]  act_chan,
  output logic             done_flag
);
  logic            flag_q;
  logic            trig_rise;
  logic            tick;
  logic            conv_busy;
  logic            conv_done;
  logic [CH_W-1:0] chan_q;
  start_kind_e     kind;

  // Source 0 is the completion flag, the rest are external lines.
  trig_edge_det #(.NSRC(NSRC), .SEL_W(SEL_W)) i_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .src   ({trig_in, flag_q}),
    .sel   (trig_sel),
    .rise  (trig_rise)
  );

  // A trigger start outranks a software start of the same cycle: one
  // conversion is launched and the prescaler restart is kept.
  always_comb begin
    kind = START_NONE;
    if (!conv_busy) begin
      if (auto_en && trig_rise) kind = START_TRIG;
      else if (sw_start)        kind = START_SW;
    end
  end

  assign start_pulse = (kind != START_NONE);
  assign presc_rst   = (kind == START_TRIG);

  conv_prescaler #(.RATIO(RATIO)) i_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (presc_rst),
    .tick    (tick)
  );

  conv_timer #(.TICKS(TICKS)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_pulse),
    .tick  (tick),
    .busy  (conv_busy),
    .done  (conv_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           chan_q <= '0;
    else if (start_pulse) chan_q <= chan_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (conv_done) flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  assign busy      = conv_busy;
  assign act_chan  = chan_q;
  assign done_flag = flag_q;
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk #(
  parameter int unsigned CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_pulse,
  input logic            presc_rst,
  input logic            busy,
  input logic [CH_W-1:0] act_chan,
  input logic            done_flag,
  input logic            flag_clr
);
  assert_busy_follows_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> busy);

  assert_chan_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(act_chan));

  assert_presc_with_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    presc_rst |-> start_pulse);

  assert_no_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_pulse);

  assert_flag_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

  assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);

  assert_single_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk #(.CH_W(CH_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_pulse (start_pulse),
  .presc_rst   (presc_rst),
  .busy        (busy),
  .act_chan    (act_chan),
  .done_flag   (done_flag),
  .flag_clr    (flag_clr)
);

// File: tb/test_adc_trig_ctrl.sv
module test_adc_trig_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sw_start, auto_en, flag_clr;
  logic [2:0] trig_sel, chan_sel;
  logic [6:0] trig_in;
  logic       start_pulse, presc_rst, busy, done_flag;
  logic [2:0] act_chan;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_trig_ctrl i_adc_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .auto_en(auto_en),
    .trig_sel(trig_sel), .trig_in(trig_in), .chan_sel(chan_sel),
    .flag_clr(flag_clr), .start_pulse(start_pulse), .presc_rst(presc_rst),
    .busy(busy), .act_chan(act_chan), .done_flag(done_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(posedge clk); #1;
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  // Called at the negedge where start_pulse was seen; returns busy length.
  task automatic run_conv(input logic [2:0] ch, input bit poke, output int n);
    n = 0;
    nxt(); sw_start = 1'b0; smp();
    while (busy === 1'b1 && n < 60) begin
      n++;
      chk("R2 act_chan during conversion", act_chan, ch);
      chk("R5 no start while busy", start_pulse, 0);
      nxt();
      if (n == 2) chan_sel = ~ch;
      if (poke) begin
        if (n == 3) trig_in = '0;
        if (n == 5) trig_in[0] = 1'b1;
        if (n == 7) sw_start = 1'b1;
        if (n == 8) sw_start = 1'b0;
      end
      smp();
    end
  endtask

  task automatic clear_flag();
    nxt(); flag_clr = 1'b1; smp();
    nxt(); flag_clr = 1'b0; smp();
    chk("R7 flag cleared by write of one", done_flag, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    if (!finished) begin
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; sw_start = 0; auto_en = 0; flag_clr = 0;
    trig_sel = '0; chan_sel = '0; trig_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    smp();
    chk("R1 reset busy", busy, 0);
    chk("R7 reset flag", done_flag, 0);
    chk("R1 reset start", start_pulse, 0);

    // R1 / R2 / R10: software single conversion
    nxt(); chan_sel = 3'd5; sw_start = 1'b1; smp();
    chk("R1 start pulse on write", start_pulse, 1);
    chk("R4 no prescaler restart on software start", presc_rst, 0);
    run_conv(3'd5, 0, n);
    chk("R10 software duration 25 or 26", int'(n == 25 || n == 26), 1);
    chk("R1 busy cleared by hardware", busy, 0);
    chk("R7 flag set at end", done_flag, 1);
    repeat (3) begin nxt(); smp(); end
    chk("R7 flag holds until cleared", done_flag, 1);
    clear_flag();

    // R3 / R4 / R6 / R10: sweep every external select with enable off and on
    for (int a = 0; a < 2; a++) begin
      for (int s = 1; s < 8; s++) begin
        nxt(); auto_en = a[0]; trig_sel = 3'(s); trig_in = '0; chan_sel = 3'(s); smp();
        nxt(); smp();
        nxt(); trig_in[s % 7] = 1'b1; smp();
        chk("R3 unselected input ignored", start_pulse, 0);
        nxt(); trig_in[s - 1] = 1'b1; smp();
        chk("R3 selected edge gated by enable", start_pulse, a);
        chk("R4 prescaler restart with trigger start", presc_rst, a);
        if (a == 1) begin
          run_conv(3'(s), 0, n);
          chk("R10 trigger duration", n, 26);
          repeat (4) begin
            nxt(); smp();
            chk("R6 held trigger does not restart", start_pulse, 0);
          end
          chk("R6 stays idle", busy, 0);
          nxt(); trig_in = '0; smp();
          clear_flag();
        end else begin
          nxt(); smp();
          chk("R3 no conversion when disabled", busy, 0);
        end
      end
    end

    // R5: edges and software writes during a conversion are ignored
    nxt(); auto_en = 1'b1; trig_sel = 3'd1; trig_in = '0; smp();
    nxt(); trig_in[0] = 1'b1; chan_sel = 3'd3; smp();
    chk("R4 start on edge", start_pulse, 1);
    run_conv(3'd3, 1, n);
    chk("R5 conversion not lengthened", n, 26);
    nxt(); smp();
    chk("R5 no late start", busy, 0);
    nxt(); trig_in = '0; smp();
    clear_flag();

    // R9: switching onto an input already high gives no edge
    nxt(); trig_sel = 3'd1; trig_in = 7'b0000010; smp();
    nxt(); smp();
    nxt(); trig_sel = 3'd2; smp();
    chk("R9 no false edge on select switch", start_pulse, 0);
    nxt(); trig_sel = 3'd3; trig_in[2] = 1'b1; chan_sel = 3'd7; smp();
    chk("R9 real edge with switch", start_pulse, 1);
    run_conv(3'd7, 0, n);
    chk("R10 trigger duration after switch", n, 26);
    nxt(); trig_in = '0; smp();
    clear_flag();

    // R8: completion flag as its own trigger
    nxt(); trig_sel = 3'd0; chan_sel = 3'd1; sw_start = 1'b1; smp();
    chk("R8 software kick", start_pulse, 1);
    run_conv(3'd1, 0, n);
    chk("R8 flag rise", done_flag, 1);
    chk("R8 flag rise restarts", start_pulse, 1);
    chk("R8 restart resets prescaler", presc_rst, 1);
    run_conv(3'd6, 0, n);
    chk("R10 chained duration", n, 26);
    repeat (4) begin
      nxt(); smp();
      chk("R8 uncleared flag blocks restart", start_pulse, 0);
    end
    nxt(); auto_en = 1'b0; smp();
    clear_flag();

    // R11: simultaneous software start and trigger edge; R7 set beats clear
    nxt(); auto_en = 1'b1; trig_sel = 3'd1; trig_in = '0; smp();
    nxt(); sw_start = 1'b1; trig_in[0] = 1'b1; flag_clr = 1'b1; chan_sel = 3'd4; smp();
    chk("R11 one start pulse", start_pulse, 1);
    chk("R11 prescaler restart kept", presc_rst, 1);
    run_conv(3'd4, 0, n);
    chk("R11 single conversion length", n, 26);
    chk("R7 set wins over clear", done_flag, 1);
    nxt(); smp();
    chk("R7 clear after set", done_flag, 0);
    chk("R11 no second conversion", busy, 0);
    nxt(); flag_clr = 1'b0; trig_in = '0; smp();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule